// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block supplies the register address for a serial read burst over a 32-entry register map. When a transaction opens, it takes a start address from the command decoder. Each time the shift engine finishes sending one register, a strobe tells the sequencer to move on to the next address.

How far the address may run before it folds back is set by a 2-bit loop-mode input, and that input can change between words. In the widest mode the address walks the whole map. In the two narrower modes it circles inside the aligned 16-address type block or inside the aligned 4-address group that holds it. In the last mode it stays where it is, so the same register is read again and again. On a fold the address goes back to the first address of its block. The register storage and the shift engine sit outside this block.

Top module: `rd_addr_seq`

## Requirements
- R1: A synchronous active-high `rst` sets `cur_addr` to 0 at the next rising edge, whatever the other inputs are.
- R2: A `xfer_start` pulse loads `start_addr` into `cur_addr` at the next rising edge.
- R3: When `xfer_start` and `word_done` are both high in the same cycle, the load wins: `cur_addr` becomes `start_addr` and is not advanced.
- R4: With `loop_mode` = 2'b11 (whole map), each `word_done` adds one to `cur_addr`, and 0x1F goes to 0x00.
- R5: With `loop_mode` = 2'b10 (type), each `word_done` adds one inside the aligned 16-address block, so 0x0F goes to 0x00 and 0x1F goes to 0x10. Bit 4 does not change.
- R6: With `loop_mode` = 2'b01 (group), each `word_done` adds one inside the aligned 4-address block, so 0x07 goes to 0x04 and 0x1B goes to 0x18. Bits 4..2 do not change.
- R7: With `loop_mode` = 2'b00 (hold), a `word_done` leaves `cur_addr` unchanged.
- R8: In a cycle with neither `xfer_start` nor `word_done` high, `cur_addr` keeps its value.
- R9: On each strobe the step uses the `loop_mode` present in that cycle. A mode change in the middle of a burst therefore applies from the next `word_done` on, and it starts from the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Transaction-open pulse; loads the start address |
| start_addr | input | 5 | First address of the burst |
| loop_mode | input | 2 | Fold range: 11 map, 10 type, 01 group, 00 hold |
| word_done | input | 1 | One register's data has been shifted out |
| cur_addr | output | 5 | Address of the register being read |

## Verification
The start pulse and the word-done strobe can arrive in the same cycle. This happens whenever a new transaction opens just as the last word of the previous one completes. The bench drives both inputs high together in a mode that would otherwise advance the address (whole map) and again in hold mode. It then checks that the output equals the new start address and not that address plus one. An assertion requires the output to follow the loaded value whenever the start pulse is present, whatever the strobe does.

// File: rtl/rd_addr_seq_pkg.sv
package rd_addr_seq_pkg;

  typedef enum logic [1:0] {
    LOOP_HOLD  = 2'b00,
    LOOP_GROUP = 2'b01,
    LOOP_TYPE  = 2'b10,
    LOOP_MAP   = 2'b11
  } loop_mode_e;

  localparam int unsigned ADDR_W_DEF  = 5;
  localparam int unsigned TYPE_W_DEF  = 4;
  localparam int unsigned GROUP_W_DEF = 2;

endpackage

// File: rtl/addr_seq_mask.sv
// Turns the loop mode into a mask of the address bits that are allowed to count.
module addr_seq_mask
  import rd_addr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned TYPE_W  = TYPE_W_DEF,
  parameter int unsigned GROUP_W = GROUP_W_DEF
) (
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] mask
);

  function automatic logic [ADDR_W-1:0] low_ones(input int unsigned n);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < n);
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] MAP_MASK   = low_ones(ADDR_W);
  localparam logic [ADDR_W-1:0] TYPE_MASK  = low_ones(TYPE_W);
  localparam logic [ADDR_W-1:0] GROUP_MASK = low_ones(GROUP_W);

  loop_mode_e mode_e;
  assign mode_e = loop_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      LOOP_MAP:   mask = MAP_MASK;
      LOOP_TYPE:  mask = TYPE_MASK;
      LOOP_GROUP: mask = GROUP_MASK;
      default:    mask = '0;
    endcase
  end

endmodule

// File: rtl/addr_seq_step.sv
// Next-address arithmetic: adds one inside the masked bits and keeps the rest.
module addr_seq_step #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] nxt,
  output logic              folds
);

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                input logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] inc;
    inc = ADDR_W'(a + 1'b1);
    return (a & ~m) | (inc & m);
  endfunction

  function automatic logic will_fold(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] m);
    return (m != '0) && ((a & m) == m);
  endfunction

  assign nxt   = advance(cur, mask);
  assign folds = will_fold(cur, mask);

endmodule

// File: rtl/addr_seq_reg.sv
// Address register; load has priority over step.
module addr_seq_reg #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_val,
  input  logic [ADDR_W-1:0] step_val,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= step_val;
  end

endmodule

// File: rtl/rd_addr_seq.sv
module rd_addr_seq
  import rd_addr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned TYPE_W  = TYPE_W_DEF,
  parameter int unsigned GROUP_W = GROUP_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        loop_mode,
  input  logic              word_done,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [ADDR_W-1:0] cnt_mask;
  logic [ADDR_W-1:0] nxt_addr;
  logic              folds;

  // Named events for the checker
  logic load_evt;
  logic step_evt;
  logic wrap_evt;

  assign load_evt = xfer_start;
  assign step_evt = word_done & ~xfer_start;
  assign wrap_evt = step_evt & folds;

  addr_seq_mask #(
    .ADDR_W (ADDR_W),
    .TYPE_W (TYPE_W),
    .GROUP_W(GROUP_W)
  ) mask_i (
    .mode(loop_mode),
    .mask(cnt_mask)
  );

  addr_seq_step #(
    .ADDR_W(ADDR_W)
  ) step_i (
    .cur  (cur_addr),
    .mask (cnt_mask),
    .nxt  (nxt_addr),
    .folds(folds)
  );

  addr_seq_reg #(
    .ADDR_W(ADDR_W)
  ) reg_i (
    .clk     (clk),
    .rst     (rst),
    .load    (load_evt),
    .step    (step_evt),
    .load_val(start_addr),
    .step_val(nxt_addr),
    .q       (cur_addr)
  );

endmodule

// File: rtl/rd_addr_seq_chk.sv
module rd_addr_seq_chk #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned TYPE_W  = 4,
  parameter int unsigned GROUP_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [1:0]        loop_mode,
  input logic              word_done,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              step_evt,
  input logic              wrap_evt
);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> cur_addr == '0);

  // R2 and R3: the loaded value wins whatever word_done does
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> cur_addr == $past(start_addr));

  a_r3_load_beats_step: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && word_done) |=> cur_addr == $past(start_addr));

  a_r4_map_inc: assert property (@(posedge clk) disable iff (rst)
    (step_evt && loop_mode == 2'b11) |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

  a_r4_map_fold: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && loop_mode == 2'b11) |=> cur_addr == '0);

  a_r5_type_block: assert property (@(posedge clk) disable iff (rst)
    (step_evt && loop_mode == 2'b10) |=>
      cur_addr[ADDR_W-1:TYPE_W] == $past(cur_addr[ADDR_W-1:TYPE_W]));

  a_r6_group_block: assert property (@(posedge clk) disable iff (rst)
    (step_evt && loop_mode == 2'b01) |=>
      cur_addr[ADDR_W-1:GROUP_W] == $past(cur_addr[ADDR_W-1:GROUP_W]));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (step_evt && loop_mode == 2'b00) |=> $stable(cur_addr));

  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    (!xfer_start && !word_done) |=> $stable(cur_addr));

endmodule

bind rd_addr_seq rd_addr_seq_chk #(
  .ADDR_W (ADDR_W),
  .TYPE_W (TYPE_W),
  .GROUP_W(GROUP_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .xfer_start(xfer_start),
  .start_addr(start_addr),
  .loop_mode (loop_mode),
  .word_done (word_done),
  .cur_addr  (cur_addr),
  .step_evt  (step_evt),
  .wrap_evt  (wrap_evt)
);

// File: tb/rd_addr_seq_tb_top.sv
`timescale 1ns/1ps
module rd_addr_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       xfer_start;
  logic [4:0] start_addr;
  logic [1:0] loop_mode;
  logic       word_done;
  logic [4:0] cur_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rd_addr_seq dut_i (
    .clk       (clk),
    .rst       (rst),
    .xfer_start(xfer_start),
    .start_addr(start_addr),
    .loop_mode (loop_mode),
    .word_done (word_done),
    .cur_addr  (cur_addr)
  );

  // {start, start_addr, mode, done, expected, requirement}
  localparam int NV = 20;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 5'h1E, 2'd3, 1'b0, 5'h1E, 4'd2},  // R2
    {1'b0, 5'h00, 2'd3, 1'b1, 5'h1F, 4'd4},  // R4
    {1'b0, 5'h00, 2'd3, 1'b1, 5'h00, 4'd4},  // R4 fold
    {1'b1, 5'h0E, 2'd2, 1'b0, 5'h0E, 4'd2},  // R2
    {1'b0, 5'h00, 2'd2, 1'b1, 5'h0F, 4'd5},  // R5
    {1'b0, 5'h00, 2'd2, 1'b1, 5'h00, 4'd5},  // R5 fold low
    {1'b1, 5'h1F, 2'd2, 1'b0, 5'h1F, 4'd2},  // R2
    {1'b0, 5'h00, 2'd2, 1'b1, 5'h10, 4'd5},  // R5 fold high
    {1'b1, 5'h06, 2'd1, 1'b0, 5'h06, 4'd2},  // R2
    {1'b0, 5'h00, 2'd1, 1'b1, 5'h07, 4'd6},  // R6
    {1'b0, 5'h00, 2'd1, 1'b1, 5'h04, 4'd6},  // R6 fold
    {1'b1, 5'h1B, 2'd1, 1'b0, 5'h1B, 4'd2},  // R2
    {1'b0, 5'h00, 2'd1, 1'b1, 5'h18, 4'd6},  // R6 fold
    {1'b0, 5'h00, 2'd0, 1'b1, 5'h18, 4'd7},  // R7
    {1'b0, 5'h00, 2'd0, 1'b0, 5'h18, 4'd8},  // R8
    {1'b1, 5'h09, 2'd3, 1'b1, 5'h09, 4'd3},  // R3
    {1'b0, 5'h00, 2'd3, 1'b1, 5'h0A, 4'd4},  // R4
    {1'b1, 5'h13, 2'd0, 1'b1, 5'h13, 4'd3},  // R3 in hold mode
    {1'b0, 5'h00, 2'd1, 1'b1, 5'h10, 4'd9},  // R9 switch to group
    {1'b0, 5'h00, 2'd3, 1'b1, 5'h11, 4'd9}   // R9 switch to map
  };

  task automatic drive(input logic s, input logic [4:0] a, input logic [1:0] m,
                       input logic d);
    xfer_start = s; start_addr = a; loop_mode = m; word_done = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [4:0] exp, input string req);
    n_cmp++;
    if (cur_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: cur_addr=%h expected=%h", req, cur_addr, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected<=5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xfer_start = 1'b0; start_addr = '0; loop_mode = 2'b10; word_done = 1'b0;
    @(negedge clk);
    drive(1'b1, 5'h15, 2'd3, 1'b1);
    check(5'h00, "R1");  // reset beats load and step
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17], VEC[i][16:12], VEC[i][11:10], VEC[i][9]);
      check(VEC[i][8:4], $sformatf("R%0d", VEC[i][3:0]));
    end

    // R8: several idle cycles keep the address
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 5'h1F, 2'd3, 1'b0);
      check(5'h11, "R8");
    end

    // R1: reset in mid-burst
    drive(1'b1, 5'h15, 2'd3, 1'b0);
    check(5'h15, "R2");
    rst = 1'b1;
    drive(1'b0, 5'h00, 2'd3, 1'b1);
    check(5'h00, "R1");
    rst = 1'b0;

    // R4: full walk with fold from the top
    drive(1'b1, 5'h1D, 2'd3, 1'b0);
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 5'h00, 2'd3, 1'b1);
      check(5'((5'h1D + k + 1) & 5'h1F), "R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule